// File: doc/BRIEF.md
# One-Time-Programmable Word Store Model

This block is a clocked, synthesizable behavioural model of a 16-bit-wide one-time-programmable memory. Its control pins are active low: a chip enable, an output enable and a program strobe. Two digital flags complete the controls. One stands in for the high programming supply. The other stands in for the raised identifier voltage on address line 9. From these inputs a combinational decoder selects one of seven operating modes. The outputs are a data word, a drive-enable that a pad ring would use to tri-state the bus, and a data-valid flag. The array depth is a parameter, so a simulation can use a small array. The full-size part has 65,536 words.

The array starts fully erased, with every word at FFFFh. A program pulse can only clear bits. Whenever the address, the mode or the erase input changes, an access state machine (`otp_access_fsm`) restarts a counter of `ACCESS_LAT` clock cycles. The output data is held at zero and marked invalid until that count completes. This models access time in cycles rather than in nanoseconds.

Access state machine: states `ST_OFF` (bus not driven), `ST_WAIT` (latency counting) and `ST_READY` (data valid). The transitions are `T_ENABLE` (OFF to WAIT when a driving mode begins), `T_RESTART` (any state to WAIT on an address, mode or erase change), `T_COUNT` (WAIT to WAIT while the count is below the latency), `T_DONE` (WAIT to READY) and `T_RELEASE` (any state to OFF when the mode stops driving). The modes are `M_STANDBY`, `M_DISABLE`, `M_READ`, `M_VERIFY`, `M_PROGRAM`, `M_INHIBIT` and `M_IDENT`.

Top module: `otp_word_store`

## Requirements
- R1: After reset, `drive_en` and `dvalid` are 0, `dout` is 0, and every word of the array reads FFFFh.
- R2: While `chip_en_n` is 1 (standby), `drive_en` is 0 and `dout` is 0, whatever the value of `out_en_n`.
- R3: With `chip_en_n` 0 and `out_en_n` 1 and no programming flag (output disable), `drive_en` is 0 and `dout` is 0.
- R4: With `chip_en_n` 0, `out_en_n` 0 and both flags 0 (read), `drive_en` is 1, and once `dvalid` is 1, `dout` equals the stored word at `addr`.
- R5: In program mode (`vpp_hi` 1, `chip_en_n` 0, `out_en_n` 1), a clock edge that samples `prog_n` at 0 after an edge that sampled it at 1 replaces the word at `addr` with the old word ANDed with `din`. A 1 is never set by programming.
- R6: With `vpp_hi` 1 and `chip_en_n` 1 (program inhibit), strobe pulses leave the array unchanged, and the outputs behave as in R2.
- R7: With `vpp_hi` 1, `chip_en_n` 0 and `out_en_n` 0 (verify), the stored word is driven as in R4.
- R8: With `id_hv` 1, `vpp_hi` 0 and both enables 0 (identifier mode), `dout` reads 0020h when `addr[0]` is 0 and 008Ch when `addr[0]` is 1. Bits 15..8 are 0, and the other address bits have no effect. When `vpp_hi` is also 1, the flag `vpp_hi` wins and verify applies.
- R9: A clock edge that samples `erase` at 1 sets every word to FFFFh in that single cycle, in any mode.
- R10: After the first edge that samples a driving mode together with a new address, a new mode or `erase`, `dvalid` rises at the `ACCESS_LAT`-th following edge. While `dvalid` is 0, `dout` is 0. An address change drops `dvalid` at once.
- R11: A strobe pulse while `out_en_n` is 0 (verify) does not write the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the array erased |
| chip_en_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output gate |
| prog_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply present flag |
| id_hv | input | 1 | Identifier voltage present on address line 9 |
| erase | input | 1 | Sets the whole array to FFFFh |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Data to program |
| dout | output | 16 | Output data, zero while not valid |
| drive_en | output | 1 | Output drive enable for tri-stating |
| dvalid | output | 1 | Output data valid |

## Verification
A wrong decoded mode shows at `drive_en` in the same cycle, because that output is combinational from the control pins. A stuck or miscounting access state machine shows as `dvalid` rising one or more edges early or late against the `ACCESS_LAT` count. A corrupted array word appears only when that address is read back, so each program, inhibit, verify-strobe and erase scenario ends with reads of both the touched words and the neighbouring words. An identifier mux fault appears on the first valid cycle of identifier mode.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_DISABLE,
        M_READ,
        M_VERIFY,
        M_PROGRAM,
        M_INHIBIT,
        M_IDENT
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT,
        ST_READY
    } acc_state_e;

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic     chip_en_n,
    input  logic     out_en_n,
    input  logic     vpp_hi,
    input  logic     id_hv,
    output op_mode_e mode,
    output logic     drive,
    output logic     prog_window
);

    always_comb begin
        mode = M_STANDBY;
        if (chip_en_n) begin
            mode = vpp_hi ? M_INHIBIT : M_STANDBY;
        end else if (vpp_hi) begin
            mode = out_en_n ? M_PROGRAM : M_VERIFY;
        end else if (id_hv) begin
            mode = out_en_n ? M_DISABLE : M_IDENT;
        end else begin
            mode = out_en_n ? M_DISABLE : M_READ;
        end
    end

    always_comb begin
        drive       = 1'b0;
        prog_window = 1'b0;
        unique case (mode)
            M_READ, M_VERIFY, M_IDENT: drive = 1'b1;
            M_PROGRAM:                 prog_window = 1'b1;
            M_STANDBY, M_DISABLE, M_INHIBIT: begin
                drive       = 1'b0;
                prog_window = 1'b0;
            end
            default: begin
                drive       = 1'b0;
                prog_window = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

    logic [DATA_W-1:0] cells [DEPTH];

    // Erase outranks a program pulse in the same cycle; programming ANDs only.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) cells[w] <= BLANK;
        end else if (erase) begin
            for (int w = 0; w < DEPTH; w++) cells[w] <= BLANK;
        end else if (wr_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/otp_access_fsm.sv
module otp_access_fsm
    import otp_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int ACCESS_LAT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_mode_e          mode,
    input  logic              drive,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    localparam int CNT_W = $clog2(ACCESS_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(ACCESS_LAT);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    acc_state_e        state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    op_mode_e          mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              restart;

    assign restart = drive && ((mode != mode_q) || (addr != addr_q) || erase);

    // Next-state logic: T_RELEASE, T_RESTART, T_ENABLE, T_COUNT, T_DONE.
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (!drive) begin
            state_nxt = ST_OFF;
            cnt_nxt   = '0;
        end else if (restart) begin
            state_nxt = ST_WAIT;
            cnt_nxt   = ONE_C;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_nxt = ST_WAIT;
                    cnt_nxt   = ONE_C;
                end
                ST_WAIT: begin
                    if (cnt >= LAT_C) begin
                        state_nxt = ST_READY;
                    end else begin
                        cnt_nxt = cnt + ONE_C;
                    end
                end
                ST_READY: state_nxt = ST_READY;
                default:  state_nxt = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            cnt    <= '0;
            mode_q <= M_STANDBY;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            state  <= state_nxt;
            cnt    <= cnt_nxt;
            mode_q <= mode;
            addr_q <= addr;
            data_q <= src_data;
        end
    end

    // Outputs.
    always_comb begin
        dvalid = 1'b0;
        unique case (state)
            ST_READY: dvalid = drive && !restart;
            ST_OFF, ST_WAIT: dvalid = 1'b0;
            default: dvalid = 1'b0;
        endcase
        dout = dvalid ? data_q : '0;
    end

endmodule

// File: rtl/otp_word_store.sv
module otp_word_store
    import otp_pkg::*;
#(
    parameter int          ADDR_W     = 6,
    parameter int          ACCESS_LAT = 3,
    parameter logic [7:0]  MFR_ID     = 8'h20,
    parameter logic [7:0]  DEV_ID     = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       din,
    output logic [15:0]       dout,
    output logic              drive_en,
    output logic              dvalid
);

    localparam int DATA_W = 16;

    op_mode_e          mode;
    logic              drive;
    logic              prog_window;
    logic              prog_q;
    logic              wr_en;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] src_word;

    otp_mode_decode u_dec (
        .chip_en_n  (chip_en_n),
        .out_en_n   (out_en_n),
        .vpp_hi     (vpp_hi),
        .id_hv      (id_hv),
        .mode       (mode),
        .drive      (drive),
        .prog_window(prog_window)
    );

    // Strobe edge detect: one write per high-to-low transition.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    assign wr_en = prog_window && prog_q && !prog_n;

    otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk    (clk),
        .rst_n  (rst_n),
        .erase  (erase),
        .wr_en  (wr_en),
        .wr_addr(addr),
        .wr_data(din),
        .rd_addr(addr),
        .rd_data(arr_word)
    );

    always_comb begin
        if (mode == M_IDENT) src_word = {8'h00, addr[0] ? DEV_ID : MFR_ID};
        else                 src_word = arr_word;
    end

    otp_access_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ACCESS_LAT(ACCESS_LAT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .drive   (drive),
        .erase   (erase),
        .addr    (addr),
        .src_data(src_word),
        .dout    (dout),
        .dvalid  (dvalid)
    );

    assign drive_en = drive;

endmodule

// File: rtl/otp_word_store_chk.sv
module otp_word_store_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en_n,
    input logic              out_en_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dout,
    input logic              drive_en,
    input logic              dvalid
);

    p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |-> (!drive_en && !dvalid && dout == 16'h0000));

    p_drive_needs_enables_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!chip_en_n && !out_en_n));

    p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid |-> (dout == 16'h0000));

    p_valid_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> $stable(addr));

    p_rise_after_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid) |-> $past(drive_en));

    p_ident_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && id_hv && !vpp_hi) |-> (dout[15:8] == 8'h00));

    p_ident_bytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid && id_hv && !vpp_hi) |->
            (dout[7:0] == (addr[0] ? 8'h8C : 8'h20)));

endmodule

bind otp_word_store otp_word_store_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en_n(chip_en_n),
    .out_en_n (out_en_n),
    .vpp_hi   (vpp_hi),
    .id_hv    (id_hv),
    .addr     (addr),
    .dout     (dout),
    .drive_en (drive_en),
    .dvalid   (dvalid)
);

// File: tb/otp_word_store_tb.sv
module otp_word_store_tb;

    localparam int AW  = 6;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic          prog_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          id_hv = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic          drive_en;
    logic          dvalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    otp_word_store #(.ADDR_W(AW), .ACCESS_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .prog_n(prog_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .erase(erase),
        .addr(addr), .din(din), .dout(dout), .drive_en(drive_en), .dvalid(dvalid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = 1'b1; prog_n = 1'b1;
        vpp_hi = 1'b0; id_hv = 1'b0; erase = 1'b0;
    endtask

    // Drive a driving mode at a negedge, wait out the latency, sample at a negedge.
    task automatic access(input logic vpp, input logic idf, input logic [AW-1:0] a,
                          output logic [15:0] d, output logic v);
        idle();
        @(negedge clk);
        chip_en_n = 1'b0; out_en_n = 1'b0; vpp_hi = vpp; id_hv = idf; addr = a;
        repeat (LAT + 1) @(posedge clk);
        @(negedge clk);
        d = dout; v = dvalid;
    endtask

    task automatic read_expect(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic        v;
        access(1'b0, 1'b0, a, d, v);
        check(req, {15'd0, v}, 16'd1);
        check(req, d, exp);
    endtask

    task automatic pulse_strobe();
        @(negedge clk); prog_n = 1'b1;
        @(negedge clk); prog_n = 1'b0;
        @(negedge clk); prog_n = 1'b1;
    endtask

    task automatic program_word(input logic [AW-1:0] a, input logic [15:0] d);
        idle();
        @(negedge clk);
        chip_en_n = 1'b0; out_en_n = 1'b1; vpp_hi = 1'b1; addr = a; din = d;
        pulse_strobe();
        idle();
    endtask

    task automatic t_reset();
        check("R1 drive_en", {15'd0, drive_en}, 16'd0);
        check("R1 dvalid", {15'd0, dvalid}, 16'd0);
        check("R1 dout", dout, 16'h0000);
        read_expect("R1 blank word 0", 6'd0, 16'hFFFF);
        read_expect("R1 blank word 63", 6'd63, 16'hFFFF);
    endtask

    task automatic t_standby();
        idle();
        @(negedge clk); out_en_n = 1'b0; addr = 6'd3;
        repeat (LAT + 2) @(negedge clk);
        check("R2 drive_en oe low", {15'd0, drive_en}, 16'd0);
        check("R2 dout oe low", dout, 16'h0000);
        out_en_n = 1'b1;
        @(negedge clk);
        check("R2 drive_en oe high", {15'd0, drive_en}, 16'd0);
    endtask

    task automatic t_disable();
        idle();
        @(negedge clk); chip_en_n = 1'b0; out_en_n = 1'b1; addr = 6'd3;
        repeat (LAT + 2) @(negedge clk);
        check("R3 drive_en", {15'd0, drive_en}, 16'd0);
        check("R3 dout", dout, 16'h0000);
    endtask

    task automatic t_program();
        program_word(6'd5, 16'hA5A5);
        read_expect("R5 first program", 6'd5, 16'hA5A5);
        program_word(6'd5, 16'h0FF0);
        read_expect("R5 and with old", 6'd5, 16'h05A0);
        program_word(6'd5, 16'hFFFF);
        read_expect("R5 ones never set", 6'd5, 16'h05A0);
        read_expect("R4 neighbour untouched", 6'd4, 16'hFFFF);
        program_word(6'd62, 16'h1234);
        read_expect("R4 read second word", 6'd62, 16'h1234);
    endtask

    task automatic t_inhibit();
        idle();
        @(negedge clk); chip_en_n = 1'b1; vpp_hi = 1'b1; addr = 6'd7; din = 16'h0000;
        pulse_strobe();
        check("R6 drive_en inhibit", {15'd0, drive_en}, 16'd0);
        check("R6 dout inhibit", dout, 16'h0000);
        pulse_strobe();
        read_expect("R6 word unchanged", 6'd7, 16'hFFFF);
    endtask

    task automatic t_verify();
        logic [15:0] d;
        logic        v;
        access(1'b1, 1'b0, 6'd5, d, v);
        check("R7 verify valid", {15'd0, v}, 16'd1);
        check("R7 verify data", d, 16'h05A0);
        din = 16'h0000;
        pulse_strobe();
        read_expect("R11 strobe in verify no write", 6'd5, 16'h05A0);
        access(1'b1, 1'b1, 6'd62, d, v);
        check("R8 vpp outranks id", d, 16'h1234);
    endtask

    task automatic t_ident();
        logic [15:0] d;
        logic        v;
        access(1'b0, 1'b1, 6'b111110, d, v);
        check("R8 ident valid", {15'd0, v}, 16'd1);
        check("R8 manufacturer", d, 16'h0020);
        access(1'b0, 1'b1, 6'b000001, d, v);
        check("R8 device", d, 16'h008C);
        access(1'b0, 1'b1, 6'b101011, d, v);
        check("R8 other bits ignored", d, 16'h008C);
    endtask

    task automatic t_latency();
        idle();
        @(negedge clk);
        chip_en_n = 1'b0; out_en_n = 1'b0; addr = 6'd62;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check("R10 not yet valid", {15'd0, dvalid}, 16'd0);
        check("R10 zero while invalid", dout, 16'h0000);
        @(negedge clk);
        check("R10 valid on time", {15'd0, dvalid}, 16'd1);
        addr = 6'd5;
        #1;
        check("R10 address change drops valid", {15'd0, dvalid}, 16'd0);
        repeat (LAT + 1) @(negedge clk);
        check("R10 new word", dout, 16'h05A0);
    endtask

    task automatic t_erase();
        idle();
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        read_expect("R9 erased word 5", 6'd5, 16'hFFFF);
        read_expect("R9 erased word 62", 6'd62, 16'hFFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standby();
        t_disable();
        t_program();
        t_inhibit();
        t_verify();
        t_ident();
        t_latency();
        t_erase();
        idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule